// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller sits between a small 8-bit processor core and its external memory bus. The core hands it one request at a time over a valid/ready handshake: an access kind (program fetch, data load or data store), a 16-bit address and, for stores, a data byte. The controller turns each request into a fixed sequence of bus phases. The upper address byte goes out on its own port. The lower address byte and the data byte share a single bidirectional port. The address goes first, marked by a latch strobe that an outside latch uses to hold the low byte. The data follows under one of three active-low strobes.

Program fetches use a strobe of their own. Data loads and stores use separate read and write strobes. An active-low external-access select decides where fetches go. When it is low, fetches go out on the bus. When it is high, fetches are answered from a small internal program image without any bus activity. Each request finishes with a one-cycle done pulse, which carries the byte read for fetches and loads.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the latch strobe is low, all three bus strobes are high, ready is high and done is low. Reset is synchronous and active high, and it abandons any access in progress.
- R2: An external access starts with ALE_CYC cycles (default 1) of the latch strobe high, with the low address byte on the shared port. One cycle with the latch strobe low and the address still driven follows. Only after that does a bus strobe fall.
- R3: From the first address cycle until the strobe rises again, the high-address port shows bits 15..8 of the accepted address and does not change, even when the request inputs change.
- R4: At most one of the program, read and write strobes is low in any cycle, and none of them is low while the latch strobe is high.
- R5: A fetch (kind code 0) taken while the external-access select is low holds the program strobe low for STROBE_CYC cycles (default 2), with the read and write strobes high. It returns the port value sampled on the last strobe cycle.
- R6: A data load (kind code 1, and also code 3) holds the read strobe low for STROBE_CYC cycles, with the program and write strobes high. It releases the shared port and returns the value sampled on the last strobe cycle.
- R7: A data store (kind code 2) holds the write strobe low for STROBE_CYC cycles, with the write byte on the shared port in every one of those cycles. The program and read strobes stay high.
- R8: A fetch taken while the external-access select is high produces no latch pulse and no strobe. In the next cycle it returns (low address byte) XOR (address bits 15..8) XOR 0x5A, where the address is first masked to its low IROM_AW bits (default 12).
- R9: Ready is high only when no access is in progress. Done is a one-cycle pulse, ALE_CYC+STROBE_CYC+2 cycles after the accepting edge for an external access and 1 cycle after it for an internal fetch. A request held valid while busy is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_kind | input | 2 | 0 fetch, 1 or 3 load, 2 store |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Store byte |
| ext_fetch_n | input | 1 | Low: fetches go to the external bus |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Fetched or loaded byte, valid with done |
| ale | output | 1 | Latch strobe, high while the low address is on the shared port |
| psen_n | output | 1 | Program strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad | inout | 8 | Shared low-address and data port |

## Verification
Two things can happen in the same cycle. The done pulse of one access can coincide with a new request that is held valid through the busy period. The latch phase of an access can coincide with the core changing its request lines. The bench keeps valid high across a whole access while it changes the address inputs. It then checks that only one done pulse appears, that the high port and the latched low byte still show the first address, and that the strobes are never low together. A mid-access reset is checked to return the bus at once to the idle levels.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2,
      ACC_LOAD2 = 2'd3
   } acc_kind_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_HOLD,
      PH_STRB,
      PH_TURN,
      PH_INT
   } phase_t;
endpackage

// File: rtl/xbus_irom.sv
module xbus_irom #(
   parameter int AW      = 16,
   parameter int DW      = 8,
   parameter int IROM_AW = 12,
   parameter logic [7:0] SEED = 8'h5A
) (
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] data
);
   logic [AW-1:0] eff;

   generate
      if (IROM_AW >= AW) begin : g_full
         assign eff = addr;
      end else begin : g_mask
         assign eff = {{(AW-IROM_AW){1'b0}}, addr[IROM_AW-1:0]};
      end
   endgenerate

   assign data = eff[DW-1:0] ^ eff[2*DW-1:DW] ^ SEED[DW-1:0];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int ALE_CYC    = 1,
   parameter int STROBE_CYC = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  acc_kind_t     req_kind,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          ext_fetch_n,
   input  logic [DW-1:0] ad_in,
   output logic          ale,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n,
   output logic          ad_oe,
   output logic [DW-1:0] ad_out,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] cap_q,
   output logic          done,
   output logic          int_hit
);
   localparam int MAXC = (ALE_CYC > STROBE_CYC) ? ALE_CYC : STROBE_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] ALE_LAST = CW'(ALE_CYC - 1);
   localparam logic [CW-1:0] STB_LAST = CW'(STROBE_CYC - 1);

   phase_t        ph;
   acc_kind_t     kind_q;
   logic [DW-1:0] wdata_q;
   logic [CW-1:0] cnt;
   logic          in_strb;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         kind_q  <= ACC_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
         cap_q   <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (req_valid) begin
               kind_q  <= req_kind;
               addr_q  <= req_addr;
               wdata_q <= req_wdata;
               cnt     <= '0;
               ph      <= (req_kind == ACC_FETCH && ext_fetch_n) ? PH_INT : PH_ADDR;
            end
            PH_ADDR: begin
               if (cnt == ALE_LAST) begin
                  cnt <= '0;
                  ph  <= PH_HOLD;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_HOLD: ph <= PH_STRB;
            PH_STRB: begin
               if (cnt == STB_LAST) begin
                  cnt <= '0;
                  ph  <= PH_TURN;
                  if (kind_q != ACC_STORE) cap_q <= ad_in;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign in_strb   = (ph == PH_STRB);
   assign req_ready = (ph == PH_IDLE);
   assign done      = (ph == PH_TURN) || (ph == PH_INT);
   assign int_hit   = (ph == PH_INT);
   assign ale       = (ph == PH_ADDR);
   assign psen_n    = !(in_strb && kind_q == ACC_FETCH);
   assign wr_n      = !(in_strb && kind_q == ACC_STORE);
   assign rd_n      = !(in_strb && (kind_q == ACC_LOAD || kind_q == ACC_LOAD2));
   assign ad_oe     = (ph == PH_ADDR) || (ph == PH_HOLD) || (in_strb && kind_q == ACC_STORE);
   assign ad_out    = in_strb ? wdata_q : addr_q[DW-1:0];

   assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
      $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
   assert_ale_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      ale |-> (psen_n && rd_n && wr_n));
   assert_gap_before_strobe_R2: assert property (@(posedge clk) disable iff (rst)
      ($fell(psen_n) || $fell(rd_n) || $fell(wr_n)) |-> !$past(ale));
   assert_store_drives_R7: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> ad_oe);
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_internal_silent_R8: assert property (@(posedge clk) disable iff (rst)
      int_hit |-> (!ale && psen_n && rd_n && wr_n));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int ALE_CYC    = 1,
   parameter int STROBE_CYC = 2,
   parameter int IROM_AW    = 12
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_kind,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          ext_fetch_n,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic          ale,
   output logic          psen_n,
   output logic          rd_n,
   output logic          wr_n,
   output logic [AW-DW-1:0] addr_hi,
   inout  wire  [DW-1:0] ad
);
   generate
      if (AW != 2 * DW) begin : g_bad_aw
         $error("xbus_ctrl: AW must be twice DW");
      end
      if (ALE_CYC < 1 || STROBE_CYC < 1) begin : g_bad_cyc
         $error("xbus_ctrl: phase lengths must be at least one cycle");
      end
      if (IROM_AW < DW || IROM_AW > AW) begin : g_bad_irom
         $error("xbus_ctrl: IROM_AW out of range");
      end
   endgenerate

   logic          ad_oe;
   logic [DW-1:0] ad_out;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] cap_q;
   logic [DW-1:0] irom_q;
   logic          int_hit;

   xbus_seq #(
      .AW(AW), .DW(DW), .ALE_CYC(ALE_CYC), .STROBE_CYC(STROBE_CYC)
   ) u_seq (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_kind   (acc_kind_t'(req_kind)),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .ext_fetch_n(ext_fetch_n),
      .ad_in      (ad),
      .ale        (ale),
      .psen_n     (psen_n),
      .rd_n       (rd_n),
      .wr_n       (wr_n),
      .ad_oe      (ad_oe),
      .ad_out     (ad_out),
      .addr_q     (addr_q),
      .cap_q      (cap_q),
      .done       (done),
      .int_hit    (int_hit)
   );

   xbus_irom #(.AW(AW), .DW(DW), .IROM_AW(IROM_AW)) u_irom (
      .addr(addr_q),
      .data(irom_q)
   );

   assign ad      = ad_oe ? ad_out : {DW{1'bz}};
   assign addr_hi = addr_q[AW-1:DW];
   assign rdata   = int_hit ? irom_q : cap_q;

   assert_hi_steady_R3: assert property (@(posedge clk) disable iff (rst)
      (!req_ready && !$past(req_ready) && !int_hit) |-> $stable(addr_hi));
endmodule

// File: tb/sim_xbus_ctrl.sv
module sim_xbus_ctrl;
   localparam int A_CYC = 1;
   localparam int S_CYC = 2;
   localparam int EXT_LAT = A_CYC + S_CYC + 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [1:0] req_kind = 2'd0;
   logic [15:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       ext_fetch_n = 1'b0;
   logic       done;
   logic [7:0] rdata;
   logic       ale, psen_n, rd_n, wr_n;
   logic [7:0] addr_hi;
   wire  [7:0] ad;

   int checks = 0;
   int errors = 0;

   xbus_ctrl u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
      .ext_fetch_n(ext_fetch_n), .done(done), .rdata(rdata), .ale(ale),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi), .ad(ad)
   );

   always #5 clk = ~clk;

   function automatic logic [7:0] ext_byte(input logic [15:0] a);
      logic [7:0] m;
      m = a[15:8] * 8'd7;
      return m + a[7:0];
   endfunction

   function automatic logic [7:0] irom_byte(input logic [15:0] a);
      logic [15:0] e;
      e = a & 16'h0FFF;
      return e[7:0] ^ e[15:8] ^ 8'h5A;
   endfunction

   // external memory model: program store returns the inverted pattern
   logic [7:0] lat_lo = '0;
   logic       mem_drv;
   logic [7:0] mem_val;
   assign mem_drv = !psen_n || !rd_n;
   assign mem_val = !psen_n ? ~ext_byte({addr_hi, lat_lo}) : ext_byte({addr_hi, lat_lo});
   assign ad = mem_drv ? mem_val : 8'hzz;

   // bus monitor
   int n_ale, n_psen, n_rd, n_wr, n_done, n_wbad, n_hibad, n_multi;
   logic [7:0] exp_hi, exp_wd;
   always @(negedge clk) begin
      if (!rst) begin
         if (ale) begin
            n_ale++;
            lat_lo = ad;
         end
         if (!psen_n) n_psen++;
         if (!rd_n) n_rd++;
         if (!wr_n) begin
            n_wr++;
            if (ad !== exp_wd) n_wbad++;
         end
         if ((ale || !psen_n || !rd_n || !wr_n) && addr_hi !== exp_hi) n_hibad++;
         if ((!psen_n + !rd_n + !wr_n) > 1 || (ale && (!psen_n || !rd_n || !wr_n))) n_multi++;
         if (done) n_done++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   int lat;
   logic [7:0] got;

   task automatic run_acc(input logic [1:0] k, input logic ean, input logic [15:0] a,
                          input logic [7:0] wd, input bit hold);
      @(negedge clk);
      req_kind = k; ext_fetch_n = ean; req_addr = a; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      n_ale = 0; n_psen = 0; n_rd = 0; n_wr = 0; n_done = 0;
      n_wbad = 0; n_hibad = 0; n_multi = 0;
      exp_hi = a[15:8]; exp_wd = wd;
      lat = 0; got = '0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         lat++;
         if (!hold) req_valid = 1'b0;
         else req_addr = ~a;
         if (done) begin
            got = rdata;
            req_valid = 1'b0;
            break;
         end
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic judge(input logic [1:0] k, input logic ean, input logic [15:0] a);
      bit intl;
      intl = (k == 2'd0) && ean;
      chk(lat == (intl ? 1 : EXT_LAT), "R9 done latency", lat, intl ? 1 : EXT_LAT);
      chk(n_done == 1, "R9 single done pulse", n_done, 1);
      chk(n_multi == 0, "R4 strobe overlap", n_multi, 0);
      if (intl) begin
         chk(n_ale + n_psen + n_rd + n_wr == 0, "R8 no bus activity", n_ale + n_psen + n_rd + n_wr, 0);
         chk(got == irom_byte(a), "R8 internal byte", got, irom_byte(a));
      end else begin
         chk(n_ale == A_CYC, "R2 latch cycles", n_ale, A_CYC);
         chk(lat_lo == a[7:0], "R2 low address latched", lat_lo, a[7:0]);
         chk(n_hibad == 0, "R3 high address steady", n_hibad, 0);
         case (k)
            2'd0: begin
               chk(n_psen == S_CYC && n_rd == 0 && n_wr == 0, "R5 fetch strobes", n_psen, S_CYC);
               chk(got == ~ext_byte(a), "R5 fetch data", got, ~ext_byte(a));
            end
            2'd2: begin
               chk(n_wr == S_CYC && n_rd == 0 && n_psen == 0, "R7 store strobes", n_wr, S_CYC);
               chk(n_wbad == 0, "R7 store byte on port", n_wbad, 0);
            end
            default: begin
               chk(n_rd == S_CYC && n_psen == 0 && n_wr == 0, "R6 load strobes", n_rd, S_CYC);
               chk(got == ext_byte(a), "R6 load data", got, ext_byte(a));
            end
         endcase
      end
   endtask

   // {kind[1:0], ext_fetch_n, addr[15:0], wdata[7:0]}
   localparam logic [26:0] VEC [0:7] = '{
      {2'd0, 1'b0, 16'h1234, 8'h00},
      {2'd1, 1'b0, 16'hA5C3, 8'h00},
      {2'd2, 1'b0, 16'h7F01, 8'h9E},
      {2'd0, 1'b1, 16'h0ABC, 8'h00},
      {2'd1, 1'b1, 16'hFFFF, 8'h00},
      {2'd2, 1'b1, 16'h0000, 8'h3C},
      {2'd3, 1'b0, 16'h8001, 8'h00},
      {2'd0, 1'b1, 16'hF123, 8'h00}
   };

   initial begin
      exp_hi = '0; exp_wd = '0;
      repeat (3) @(negedge clk);
      chk(!ale && psen_n && rd_n && wr_n, "R1 strobes idle in reset", {ale, psen_n, rd_n, wr_n}, 4'b0111);
      rst = 1'b0;
      @(negedge clk);
      chk(req_ready && !done, "R1 ready after reset", {req_ready, done}, 2'b10);

      foreach (VEC[i]) begin
         run_acc(VEC[i][26:25], VEC[i][24], VEC[i][23:8], VEC[i][7:0], 1'b0);
         judge(VEC[i][26:25], VEC[i][24], VEC[i][23:8]);
      end

      // request held valid and changing while busy: taken once, bus keeps first address (R9, R3)
      run_acc(2'd1, 1'b0, 16'h3C5A, 8'h00, 1'b1);
      judge(2'd1, 1'b0, 16'h3C5A);
      chk(req_ready, "R9 idle after held request", req_ready, 1);

      // reset in the middle of a store (R1)
      @(negedge clk);
      req_kind = 2'd2; ext_fetch_n = 1'b0; req_addr = 16'h4455; req_wdata = 8'h11; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(!ale && psen_n && rd_n && wr_n && req_ready && !done, "R1 mid-access reset",
          {ale, psen_n, rd_n, wr_n, req_ready, done}, 6'b011110);
      rst = 1'b0;
      run_acc(2'd0, 1'b0, 16'hBEEF, 8'h00, 1'b0);
      judge(2'd0, 1'b0, 16'hBEEF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule